// File: doc/BRIEF.md
# Double-Rate Write Capture with Byte Enables

This block is the write data path of a 16-bit double-data-rate memory. Write data and its per-byte mask arrive together on a 16-bit bus, already aligned to the strobe. Here the strobe is the block clock. A half-word is taken on the rising edge and another on the falling edge. The two halves of one clock period are joined into a single 32-bit core word, which is a 2n prefetch. That word goes to the array side as one write beat. Each beat carries four active-high byte enables and an even column address.

A write command carries a start column and a burst length code. The data transfers begin on the clock edge after the command. The block counts beats against the programmed length and moves the column through the aligned burst block, wrapping inside it. A completion pulse follows the last beat. A new command that arrives in the middle of a burst cuts that burst short and starts counting again from the new column.

Top module: `ddr_wrcap_top`

## Requirements
- R1: The half-word sampled on a rising clock edge fills beat_data_o[15:0], and the half-word sampled on the following falling edge fills beat_data_o[31:16] of the same beat.
- R2: A mask bit sampled high with a half-word clears that byte's enable, so the byte is not written. A mask bit sampled low sets it. beat_be_o[0] and [1] are the low and high bytes of the rising half-word. beat_be_o[2] and [3] are the low and high bytes of the falling half-word.
- R3: dm_i[0] governs data bits 7:0 and dm_i[1] governs data bits 15:8, on both edges.
- R4: A data period starts at rising edge d. Its beat is presented, with beat_valid_o high, for the cycle after rising edge d+1. At most one beat is presented per cycle.
- R5: The length code is sampled with the command. Code 0 gives 2 transfers, code 1 gives 4, and codes 2 and 3 give 8. These make 1, 2 or 4 beats, whose data periods start on the rising edges right after the command.
- R6: The start column has bit 0 forced to zero. Each later beat adds 2 to the column, wrapping inside the block of (transfers) columns aligned to that size. Columns above the block stay fixed.
- R7: burst_done_o is high for exactly one cycle, in the cycle after the last beat of a burst that ran to its full length.
- R8: A command that arrives before the current burst ends lets only the data periods up to and including its own edge belong to the old burst. The old burst then gives no completion pulse, and the count restarts at the new column.
- R9: While rst is high, beat_valid_o and burst_done_o are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write strobe used as clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd_i | input | 1 | Write command, sampled on the rising edge |
| wr_col_i | input | COL_W (10) | Start column of the burst |
| bl_code_i | input | 2 | Burst length code |
| dq_i | input | 16 | Write half-word, sampled on both edges |
| dm_i | input | 2 | Byte mask for the half-word, high means do not write |
| beat_valid_o | output | 1 | Core write beat present |
| beat_data_o | output | 32 | Core write word, rising half low |
| beat_be_o | output | 4 | Active-high byte enables |
| beat_col_o | output | COL_W (10) | Column of the beat |
| burst_done_o | output | 1 | One-cycle pulse after a completed burst |

## Verification
Two things can fall on the same rising edge: a new command, and the capture of a data period that still belongs to the old burst. A burst can also take its final data on the same edge that a new command is sampled. The bench sets up both cases. One is an 8-transfer burst cut after two periods. The other is a 2-transfer burst issued right behind a 4-transfer burst, so one edge ends the old burst and starts the new one. A queue-free behavioural model works out the owner of each data period from the command times. On every cycle it checks that the old beats still come out, that the completion pulse appears only for the burst that ran to its end, and that the new columns count from the new start.

// File: rtl/ddr_wrcap_pkg.sv
package ddr_wrcap_pkg;
  localparam int BL_CODE_W = 2;
  localparam int BEAT_CNT_W = 3;

  function automatic logic [BEAT_CNT_W-1:0] beats_for_code(input logic [BL_CODE_W-1:0] code);
    case (code)
      2'd0:    beats_for_code = 3'd1;
      2'd1:    beats_for_code = 3'd2;
      default: beats_for_code = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ddr_wrcap_lane.sv
module ddr_wrcap_lane #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_en,
  input  logic [BYTE_W-1:0] d_i,
  input  logic              m_i,
  output logic [BYTE_W-1:0] rise_d_o,
  output logic              rise_m_o,
  output logic [BYTE_W-1:0] fall_d_o,
  output logic              fall_m_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_d_o <= '0;
      rise_m_o <= 1'b1;
    end else if (rise_en) begin
      rise_d_o <= d_i;
      rise_m_o <= m_i;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      fall_d_o <= '0;
      fall_m_o <= 1'b1;
    end else begin
      fall_d_o <= d_i;
      fall_m_o <= m_i;
    end
  end
endmodule

// File: rtl/ddr_wrcap_seq.sv
module ddr_wrcap_seq
  import ddr_wrcap_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_cmd_i,
  input  logic [COL_W-1:0]     wr_col_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  output logic                 take_o,
  output logic                 cap_valid_o,
  output logic                 cap_last_o,
  output logic [COL_W-1:0]     cap_col_o
);
  logic                  active_q;
  logic [BEAT_CNT_W-1:0] idx_q;
  logic [BEAT_CNT_W-1:0] nbeats_q;
  logic [COL_W-1:0]      base_q;
  logic [COL_W-1:0]      wrap_mask;
  logic [COL_W-1:0]      step_col;
  logic [COL_W-1:0]      cur_col;
  logic                  at_last;

  assign take_o    = active_q;
  assign wrap_mask = COL_W'({nbeats_q, 1'b0}) - COL_W'(1);
  assign step_col  = base_q + COL_W'({idx_q, 1'b0});
  assign cur_col   = ((base_q & ~wrap_mask) | (step_col & wrap_mask)) & ~COL_W'(1);
  assign at_last   = (idx_q == nbeats_q - BEAT_CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      idx_q       <= '0;
      nbeats_q    <= BEAT_CNT_W'(1);
      base_q      <= '0;
      cap_valid_o <= 1'b0;
      cap_last_o  <= 1'b0;
      cap_col_o   <= '0;
    end else begin
      cap_valid_o <= active_q;
      cap_last_o  <= active_q && at_last;
      if (active_q) begin
        cap_col_o <= cur_col;
        idx_q     <= idx_q + BEAT_CNT_W'(1);
        if (at_last) active_q <= 1'b0;
      end
      if (wr_cmd_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= wr_col_i;
        nbeats_q <= beats_for_code(bl_code_i);
      end
    end
  end

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    wr_cmd_i |=> (active_q && idx_q == '0));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (idx_q < nbeats_q));
  p_col_even_r6: assert property (@(posedge clk) disable iff (rst)
    cap_valid_o |-> (cap_col_o[0] == 1'b0));
endmodule

// File: rtl/ddr_wrcap_pack.sv
module ddr_wrcap_pack #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  parameter int COL_W  = 10,
  localparam int HALF_W = LANES * BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_valid_i,
  input  logic                cap_last_i,
  input  logic [COL_W-1:0]    cap_col_i,
  input  logic [HALF_W-1:0]   rise_d_i,
  input  logic [LANES-1:0]    rise_m_i,
  input  logic [HALF_W-1:0]   fall_d_i,
  input  logic [LANES-1:0]    fall_m_i,
  output logic                beat_valid_o,
  output logic [2*HALF_W-1:0] beat_data_o,
  output logic [2*LANES-1:0]  beat_be_o,
  output logic [COL_W-1:0]    beat_col_o,
  output logic                burst_done_o
);
  logic beat_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid_o <= 1'b0;
      beat_last_q  <= 1'b0;
      beat_data_o  <= '0;
      beat_be_o    <= '0;
      beat_col_o   <= '0;
      burst_done_o <= 1'b0;
    end else begin
      beat_valid_o <= cap_valid_i;
      beat_last_q  <= cap_valid_i && cap_last_i;
      burst_done_o <= beat_valid_o && beat_last_q;
      if (cap_valid_i) begin
        beat_data_o <= {fall_d_i, rise_d_i};
        beat_be_o   <= ~{fall_m_i, rise_m_i};
        beat_col_o  <= cap_col_i;
      end
    end
  end

  p_beat_follows_r4: assert property (@(posedge clk) disable iff (rst)
    cap_valid_i |=> beat_valid_o);
  p_done_after_beat_r7: assert property (@(posedge clk) disable iff (rst)
    burst_done_o |-> $past(beat_valid_o));
endmodule

// File: rtl/ddr_wrcap_top.sv
module ddr_wrcap_top
  import ddr_wrcap_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  parameter int COL_W  = 10,
  localparam int HALF_W = LANES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_cmd_i,
  input  logic [COL_W-1:0]     wr_col_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic [HALF_W-1:0]    dq_i,
  input  logic [LANES-1:0]     dm_i,
  output logic                 beat_valid_o,
  output logic [2*HALF_W-1:0]  beat_data_o,
  output logic [2*LANES-1:0]   beat_be_o,
  output logic [COL_W-1:0]     beat_col_o,
  output logic                 burst_done_o
);
  logic              take;
  logic              cap_valid;
  logic              cap_last;
  logic [COL_W-1:0]  cap_col;
  logic [HALF_W-1:0] rise_d;
  logic [HALF_W-1:0] fall_d;
  logic [LANES-1:0]  rise_m;
  logic [LANES-1:0]  fall_m;

  ddr_wrcap_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst(rst), .wr_cmd_i(wr_cmd_i), .wr_col_i(wr_col_i),
    .bl_code_i(bl_code_i), .take_o(take), .cap_valid_o(cap_valid),
    .cap_last_o(cap_last), .cap_col_o(cap_col)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_wrcap_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst(rst), .rise_en(take),
      .d_i(dq_i[g*BYTE_W +: BYTE_W]), .m_i(dm_i[g]),
      .rise_d_o(rise_d[g*BYTE_W +: BYTE_W]), .rise_m_o(rise_m[g]),
      .fall_d_o(fall_d[g*BYTE_W +: BYTE_W]), .fall_m_o(fall_m[g])
    );
  end

  ddr_wrcap_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .COL_W(COL_W)) u_pack (
    .clk(clk), .rst(rst), .cap_valid_i(cap_valid), .cap_last_i(cap_last),
    .cap_col_i(cap_col), .rise_d_i(rise_d), .rise_m_i(rise_m),
    .fall_d_i(fall_d), .fall_m_i(fall_m), .beat_valid_o(beat_valid_o),
    .beat_data_o(beat_data_o), .beat_be_o(beat_be_o), .beat_col_o(beat_col_o),
    .burst_done_o(burst_done_o)
  );

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!beat_valid_o && !burst_done_o));
endmodule

// File: tb/ddr_wrcap_top_test.sv
`timescale 1ns/1ps
module ddr_wrcap_top_test;
  localparam int N = 48;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_cmd = 1'b0;
  logic [CW-1:0] wr_col = '0;
  logic [1:0] bl_code = '0;
  logic [15:0] dq = '0;
  logic [1:0] dm = '0;
  logic bv, bd;
  logic [31:0] bdata;
  logic [3:0] bbe;
  logic [CW-1:0] bcol;

  always #5 clk = ~clk;

  ddr_wrcap_top uut (
    .clk(clk), .rst(rst), .wr_cmd_i(wr_cmd), .wr_col_i(wr_col),
    .bl_code_i(bl_code), .dq_i(dq), .dm_i(dm), .beat_valid_o(bv),
    .beat_data_o(bdata), .beat_be_o(bbe), .beat_col_o(bcol), .burst_done_o(bd)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  bit          cmd_a [N];
  int          col_a [N];
  int          code_a[N];
  logic [15:0] dr_a  [N];
  logic [15:0] df_a  [N];
  logic [1:0]  mr_a  [N];
  logic [1:0]  mf_a  [N];
  bit          ev    [N+4];
  logic [31:0] ed    [N+4];
  logic [3:0]  ebe   [N+4];
  int          ecol  [N+4];
  bit          edone [N+4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_cmd(input int c, input int col, input int code);
    cmd_a[c] = 1; col_a[c] = col; code_a[c] = code;
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      cmd_a[c] = 0; col_a[c] = 0; code_a[c] = 0;
      dr_a[c] = 16'((c * 16'h1357) ^ 16'h5A00);
      df_a[c] = 16'((c * 16'h0B1D) ^ 16'h00C3);
      mr_a[c] = 2'((c * 3) % 4);
      mf_a[c] = 2'((c * 5 + 1) % 4);
    end
    for (int c = 0; c < N + 4; c++) begin
      ev[c] = 0; ed[c] = '0; ebe[c] = '0; ecol[c] = 0; edone[c] = 0;
    end
    put_cmd(1, 99, 2);
    put_cmd(4, 5, 2);
    put_cmd(10, 18, 1);
    put_cmd(12, 33, 0);
    put_cmd(16, 40, 3);
    put_cmd(18, 7, 1);
    put_cmd(24, 13, 0);
    put_cmd(25, 64, 2);
    put_cmd(34, 1022, 2);

    for (int c = 3; c < N; c++) begin
      if (cmd_a[c]) begin
        int tr, nb, base, blk, off, d;
        bit cut;
        tr = (code_a[c] == 0) ? 2 : (code_a[c] == 1) ? 4 : 8;
        nb = tr / 2;
        base = col_a[c] - (col_a[c] % 2);
        blk = base - (base % tr);
        off = base % tr;
        cut = 0;
        for (int j = 0; j < nb; j++) begin
          d = c + 1 + j;
          for (int m = c + 1; m < d; m++) if (cmd_a[m]) cut = 1;
          if (cut || d >= N) begin
            cut = 1;
            break;
          end
          ev[d+1]   = 1;
          ed[d+1]   = {df_a[d], dr_a[d]};
          ebe[d+1]  = ~{mf_a[d], mr_a[d]};
          ecol[d+1] = (blk + (off + 2 * j) % tr) % (1 << CW);
          if (j == nb - 1) edone[d+2] = 1;
        end
      end
    end

    for (int c = 0; c < N; c++) begin
      rst    = (c < 3);
      wr_cmd = cmd_a[c];
      wr_col = CW'(col_a[c]);
      bl_code = 2'(code_a[c]);
      dq = dr_a[c];
      dm = mr_a[c];
      @(posedge clk);
      #1;
      dq = df_a[c];
      dm = mf_a[c];
      #3;
      if (c < 3) begin
        chk(bv == 1'b0, "R9 valid in reset", 32'(bv), 32'd0);
        chk(bd == 1'b0, "R9 done in reset", 32'(bd), 32'd0);
      end else begin
        chk(bv == ev[c], "R4/R5/R8 beat valid", 32'(bv), 32'(ev[c]));
        chk(bd == edone[c], "R7/R8 burst done", 32'(bd), 32'(edone[c]));
        if (ev[c] && bv) begin
          chk(bdata[15:0] == ed[c][15:0], "R1 rising half", bdata, ed[c]);
          chk(bdata[31:16] == ed[c][31:16], "R1 falling half", bdata, ed[c]);
          chk(bbe == ebe[c], "R2/R3 byte enables", 32'(bbe), 32'(ebe[c]));
          chk(int'(bcol) == ecol[c], "R6 column", 32'(bcol), 32'(ecol[c]));
        end
      end
      @(negedge clk);
      #1;
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule